// File: doc/BRIEF.md
# Dual-bus DMA configuration checker

This block guards the start of a DMA engine whose two bus master ports sit on different buses, one external and one internal. When software pulses start, the block captures the source address, destination address, direction bit, both burst length codes, both data width codes and the beat count. In the following cycle it judges whether that configuration can be carried out. A legal configuration launches the transfer. An illegal one raises the error flag and moves no data.

While a transfer runs, a beat counter stands in for the data path. Each accepted beat counts toward the programmed total. An error response from a bus slave aborts the run at once. Software reads the outcome from a 32-bit read-only status word that holds three flags: done, busy and error.

Each address is assigned to a bus side with a parameterised base and mask. An address is external when `(addr & EXT_MASK) == EXT_BASE`; otherwise it is internal.

Top module: `dma_cfg_guard`

## Requirements
- R1: The status word holds done at bit 18, busy at bit 17 and error at bit 16. Every other bit reads 0. All three flags are 0 after reset.
- R2: Suppose a start pulse is sampled at clock edge N while idle and the configuration is legal with a nonzero count. Busy then reads 1 after edge N+1 and stays 1 until the transfer ends.
- R3: The transfer ends when `xfer_beats` beats have been counted. A beat is counted when `beat_ok` is 1 at a clock edge while busy. On the edge that counts the last beat, busy clears and done sets together.
- R4: If `slave_err` is 1 at an edge while busy, busy clears, error sets and done stays 0 on that edge. This holds even when a beat is offered on the same edge.
- R5: Source and destination must be on opposite buses. A pairing with both addresses external, or both internal, sets error one edge after the start edge, and busy never rises.
- R6: Direction bit 0 means external to internal, so the source must be external. Direction bit 1 means internal to external, so the source must be internal. A direction bit that disagrees with the decoded addresses sets error and busy never rises.
- R7: Burst length and data width fields are 2 bits wide. Codes 0, 1 and 2 are valid and code 3 is reserved. Code 3 in any of the four fields (source burst, destination burst, source width, destination width) sets error and busy never rises.
- R8: An accepted start pulse clears done and error on the start edge itself, before its checks are applied.
- R9: A start pulse is ignored while busy is 1, and also on the edge right after an accepted start. Such a pulse does not restart the run or change the captured configuration.
- R10: A legal configuration with a beat count of 0 sets done one edge after the start edge, and busy never rises.
- R11: An address is external exactly when `(addr & EXT_MASK) == EXT_BASE`. With the default parameters an address is external exactly when its top nibble is 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled on the rising edge |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| dir_i2e | input | 1 | Direction: 0 external to internal, 1 internal to external |
| src_blen | input | 2 | Source burst length code |
| dst_blen | input | 2 | Destination burst length code |
| src_size | input | 2 | Source data width code |
| dst_size | input | 2 | Destination data width code |
| xfer_beats | input | CW | Number of beats to transfer |
| beat_ok | input | 1 | One data beat accepted this cycle |
| slave_err | input | 1 | Error response from a bus slave |
| status | output | 32 | Status word: done, busy and error flags |

## Verification
An accepted start is visible one edge later, when done and error read 0. Busy or error appears on the edge after that. A last beat or an error response changes the flags on the edge that samples it.

The bench drives inputs on falling edges. A behavioural model updates on each rising edge, and the status is compared with it on every falling edge. Targeted checks sample at those same falling edges, counted from the edge on which the start pulse was taken.

// File: rtl/dma_cfg_guard.sv
module dma_cfg_guard #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter logic [AW-1:0] EXT_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] EXT_MASK = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          dir_i2e,
  input  logic [1:0]    src_blen,
  input  logic [1:0]    dst_blen,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  input  logic [CW-1:0] xfer_beats,
  input  logic          beat_ok,
  input  logic          slave_err,
  output logic [31:0]   status
);

  logic          pend_q, busy_q, done_q, err_q;
  logic [AW-1:0] src_q, dst_q;
  logic          dir_q;
  logic [7:0]    fmt_q;
  logic [CW-1:0] total_q, cnt_q;

  wire src_ext  = (src_q & EXT_MASK) == EXT_BASE;
  wire dst_ext  = (dst_q & EXT_MASK) == EXT_BASE;
  wire pair_bad = src_ext == dst_ext;
  wire dir_bad  = dir_q != dst_ext;
  wire fmt_bad  = (&fmt_q[7:6]) | (&fmt_q[5:4]) | (&fmt_q[3:2]) | (&fmt_q[1:0]);
  wire cfg_bad  = pair_bad | dir_bad | fmt_bad;
  wire take     = start & ~busy_q & ~pend_q;
  wire [CW-1:0] cnt_nxt = cnt_q + 1'b1;

  assign status = {13'd0, done_q, busy_q, err_q, 16'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      dir_q   <= 1'b0;
      fmt_q   <= '0;
      total_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (take) begin
        pend_q  <= 1'b1;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
        src_q   <= src_addr;
        dst_q   <= dst_addr;
        dir_q   <= dir_i2e;
        fmt_q   <= {src_blen, dst_blen, src_size, dst_size};
        total_q <= xfer_beats;
      end
      if (pend_q) begin
        pend_q <= 1'b0;
        if (cfg_bad)
          err_q <= 1'b1;
        else if (total_q == '0)
          done_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end
      if (busy_q) begin
        if (slave_err) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else if (beat_ok) begin
          if (cnt_nxt == total_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else
            cnt_q <= cnt_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/dma_cfg_guard_chk.sv
module dma_cfg_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        slave_err,
  input logic [31:0] status
);
  wire done = status[18];
  wire busy = status[17];
  wire err  = status[16];

  // R1
  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:19] == '0) && (status[15:0] == '0));

  // R3
  a_r3_done_not_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  a_r4_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    busy && slave_err |=> !busy && err && !done);

  // R5
  a_r5_no_busy_with_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && err));

  // R8
  a_r8_start_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !$past(start) |=> !done && !err);

  // R9
  a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done || err);
endmodule

bind dma_cfg_guard dma_cfg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .slave_err(slave_err), .status(status)
);

// File: tb/tb_dma_cfg_guard.sv
`timescale 1ns/1ps
module tb_dma_cfg_guard;
  logic clk = 0, rst_n = 0, start = 0, dir_i2e = 0, beat_ok = 0, slave_err = 0;
  logic [31:0] src_addr = 0, dst_addr = 0;
  logic [1:0] src_blen = 0, dst_blen = 0, src_size = 0, dst_size = 0;
  logic [15:0] xfer_beats = 0;
  logic [31:0] status;
  logic beat_en = 0;
  int checks = 0, failures = 0, cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  dma_cfg_guard dut (.clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .dir_i2e(dir_i2e), .src_blen(src_blen), .dst_blen(dst_blen),
    .src_size(src_size), .dst_size(dst_size), .xfer_beats(xfer_beats),
    .beat_ok(beat_ok), .slave_err(slave_err), .status(status));

  function automatic bit is_ext(logic [31:0] a);
    return a[31:28] == 4'h8;
  endfunction

  // behavioural reference: phase 0 idle, 1 judging, 2 moving
  int ph = 0, m_got = 0, m_total = 0;
  bit m_done = 0, m_err = 0, m_ok = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_done = 0; m_err = 0;
    end else if (ph == 0) begin
      if (start) begin
        m_done = 0; m_err = 0; ph = 1; m_total = xfer_beats;
        m_ok = (is_ext(src_addr) != is_ext(dst_addr)) &&
               (dir_i2e ? !is_ext(src_addr) : is_ext(src_addr)) &&
               src_blen != 3 && dst_blen != 3 && src_size != 3 && dst_size != 3;
      end
    end else if (ph == 1) begin
      if (!m_ok) begin m_err = 1; ph = 0; end
      else if (m_total == 0) begin m_done = 1; ph = 0; end
      else begin m_got = 0; ph = 2; end
    end else begin
      if (slave_err) begin m_err = 1; ph = 0; end
      else if (beat_ok) begin
        m_got++;
        if (m_got == m_total) begin m_done = 1; ph = 0; end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    beat_ok = beat_en ? 1'($urandom & 1) : 1'b0;
    if (rst_n)
      chk("R1 R2 R3 model", status,
          {13'd0, m_done, 1'(ph == 2), m_err, 16'd0});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic setup(logic [31:0] s, logic [31:0] d, logic dr, logic [1:0] sb,
                       logic [1:0] db, logic [1:0] sw, logic [1:0] dw, int n);
    src_addr = s; dst_addr = d; dir_i2e = dr; src_blen = sb; dst_blen = db;
    src_size = sw; dst_size = dw; xfer_beats = 16'(n);
  endtask

  // start sampled at one edge; returns at the falling edge after the next edge
  task automatic kick(string tag);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk({tag, " R8 cleared"}, status, 32'h0);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && status[17]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", status, 32'h0);
    rst_n = 1;
    beat_en = 1;

    setup(32'h8000_0100, 32'h0000_2000, 0, 0, 1, 2, 2, 5);
    kick("R2");
    chk("R2 busy", status, 32'h0002_0000);
    wait_idle();
    chk("R3 done e2i", status, 32'h0004_0000);

    setup(32'h1234_0000, 32'h8FFF_FFFC, 1, 2, 2, 0, 1, 3);
    kick("R11");
    chk("R11 i2e busy", status, 32'h0002_0000);
    wait_idle();
    chk("R3 done i2e", status, 32'h0004_0000);

    setup(32'h8000_0000, 32'h8100_0000, 0, 0, 0, 0, 0, 4);
    kick("R5");
    chk("R5 both ext", status, 32'h0001_0000);
    setup(32'h0000_0000, 32'h9000_0000, 1, 0, 0, 0, 0, 4);
    kick("R5");
    chk("R5 R11 both int", status, 32'h0001_0000);

    setup(32'h8000_0000, 32'h0000_0000, 1, 0, 0, 0, 0, 4);
    kick("R6");
    chk("R6 dir mismatch a", status, 32'h0001_0000);
    setup(32'h0000_0000, 32'h8000_0000, 0, 0, 0, 0, 0, 4);
    kick("R6");
    chk("R6 dir mismatch b", status, 32'h0001_0000);

    for (int f = 0; f < 4; f++) begin
      setup(32'h8000_0000, 32'h0000_0000, 0, f == 0 ? 2'd3 : 2'd1,
            f == 1 ? 2'd3 : 2'd2, f == 2 ? 2'd3 : 2'd0, f == 3 ? 2'd3 : 2'd2, 4);
      kick("R7");
      chk($sformatf("R7 reserved field %0d", f), status, 32'h0001_0000);
    end

    setup(32'h8000_0000, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
    kick("R10");
    chk("R10 zero count", status, 32'h0004_0000);

    setup(32'h8000_0000, 32'h0000_0000, 0, 1, 1, 1, 1, 50);
    kick("R4");
    repeat (4) @(negedge clk);
    beat_en = 0;
    @(negedge clk);
    beat_ok = 1; slave_err = 1;
    @(negedge clk) slave_err = 0;
    chk("R4 abort", status, 32'h0001_0000);
    beat_en = 1;

    setup(32'h0000_0040, 32'h8000_0040, 1, 0, 0, 2, 2, 40);
    @(negedge clk) start = 1;
    @(negedge clk) setup(32'h8000_0000, 32'h8000_0000, 0, 3, 3, 3, 3, 1);
    @(negedge clk);
    chk("R9 pending start ignored", status, 32'h0002_0000);
    @(negedge clk) start = 0;
    chk("R9 busy start ignored", status, 32'h0002_0000);
    wait_idle();
    chk("R9 run completes", status, 32'h0004_0000);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule